// File: doc/BRIEF.md
# Dual-Clock FIFO with Retransmit

This block is a first-in first-out buffer with separate write and read clocks. It stores 18-bit words in a memory whose depth is a power-of-two parameter. The write side and the read side exchange their pointers as Gray code through a chain of synchronising flops. The read-side flags are built in the read clock domain and the write-side flags are built in the write clock domain.

The timing mode is captured from the `fwft_sel` pin while master reset is held low. In standard mode a word is presented on `dout` one read-clock edge after a read is requested. `rd_flag` then means empty and `wr_flag` means full. In fall-through mode the oldest word is placed on `dout` without any read request. `rd_flag` then means that valid output data is present and `wr_flag` means that a write will be accepted.

A partial reset empties the buffer but keeps the captured mode. The rewind input sends the read pointer back to the first memory location, so that the words written since the last reset can be read again. Almost-empty and almost-full thresholds come in as inputs from an external offset unit.

Top module: `dcx_fifo`

## Requirements
- R1: After master reset, standard mode shows rd_flag=1 and wr_flag=0, and fall-through mode shows rd_flag=0 and wr_flag=1. In both modes half_full=0, almost_empty=1 and almost_full=0 (when af_lvl < DEPTH).
- R2: The mode is the level of fwft_sel (1 = fall-through, 0 = standard) sampled while mrst_n is low. Later changes of fwft_sel have no effect on the mode.
- R3: In standard mode, each read-clock edge with ren=1 and the buffer not empty loads the oldest stored word onto dout. Words leave in the order they were written.
- R4: A write presented while the buffer holds DEPTH words is dropped, and the write pointer does not move.
- R5: A read presented while the buffer is empty is ignored, and the read pointer does not move.
- R6: The full condition (wr_flag=1 in standard mode) holds exactly when DEPTH words are stored. The empty condition (rd_flag=1 in standard mode) holds exactly when no words are stored.
- R7: half_full is 1 when more than DEPTH/2 words are stored, and 0 otherwise.
- R8: almost_empty is 1 when the stored word count is at or below ae_lvl. almost_full is 1 when the free space is at or below af_lvl.
- R9: In fall-through mode the oldest word appears on dout with no read request, and rd_flag rises together with it. The word and the flag hold until a read-clock edge with ren=1 consumes the word.
- R10: A read-clock edge with rewind=1 sets the read pointer to the first location. Any read request in that same cycle is ignored. The next word delivered is the first word written since the last reset.
- R11: prst_n=0 empties the buffer and resets both pointers, but keeps the mode captured at master reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low; captures the mode |
| prst_n | input | 1 | Partial reset, active low; keeps the mode |
| fwft_sel | input | 1 | Mode select sampled during master reset (1 = fall-through) |
| wen | input | 1 | Write request |
| din | input | 18 | Write data |
| ren | input | 1 | Read request |
| rewind | input | 1 | Rewind the read pointer to the first location |
| ae_lvl | input | $clog2(DEPTH)+1 | Almost-empty threshold |
| af_lvl | input | $clog2(DEPTH)+1 | Almost-full threshold |
| dout | output | 18 | Read data |
| rd_flag | output | 1 | Empty (standard mode) or output ready (fall-through mode) |
| wr_flag | output | 1 | Full (standard mode) or input ready (fall-through mode) |
| half_full | output | 1 | More than half of the depth is occupied |
| almost_empty | output | 1 | Word count at or below ae_lvl |
| almost_full | output | 1 | Free space at or below af_lvl |

## Verification
A rewind and a read request can arrive on the same read-clock edge, and the rewind must win. The bench provokes this by raising `ren` together with `rewind` partway through a stream of reads, in standard mode. When its monitor sees the rewind, it reloads the expected queue with every word written since the last reset, and it records no pop for that edge. Every later word on `dout` is then judged against that reloaded queue, from the first word onward. The same rewind is repeated in fall-through mode, where the first word must reappear on `dout` with no read request.

// File: rtl/dcx_fifo_pkg.sv
package dcx_fifo_pkg;
   localparam int DATA_W = 18;

   typedef enum logic {
      MODE_STD  = 1'b0,
      MODE_FWFT = 1'b1
   } fifo_mode_e;
endpackage

// File: rtl/dcx_ptr_sync.sv
module dcx_ptr_sync #(
   parameter int W      = 7,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_gray,
   output logic [W-1:0] q_gray
);
   logic [STAGES-1:0][W-1:0] stg;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dcx_ptr_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d_gray};
   end

   assign q_gray = stg[STAGES-1];
endmodule

// File: rtl/dcx_wr_ctl.sv
module dcx_wr_ctl
   import dcx_fifo_pkg::*;
#(
   parameter  int DEPTH = 64,
   localparam int AW    = $clog2(DEPTH),
   localparam int PW    = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mrst_n,
   input  logic          mode_pin,
   input  logic          wen,
   input  logic [PW-1:0] rgray_s,
   input  logic [PW-1:0] af_lvl,
   output logic [PW-1:0] wptr,
   output logic [PW-1:0] wgray,
   output logic          mem_we,
   output logic          full,
   output logic          flag_f,
   output logic          half_full,
   output logic          almost_full
);
   fifo_mode_e    mode_q;
   logic [PW-1:0] rbin;
   logic [PW-1:0] wcount;
   logic [PW-1:0] wptr_nx;
   logic [PW:0]   free;

   always_ff @(posedge clk) begin
      if (!mrst_n) mode_q <= fifo_mode_e'(mode_pin);
   end

   always_comb begin
      for (int i = 0; i < PW; i++) rbin[i] = ^(rgray_s >> i);
   end

   assign wcount      = wptr - rbin;
   assign full        = (wcount >= PW'(DEPTH));
   assign free        = {1'b0, PW'(DEPTH)} - {1'b0, wcount};
   assign half_full   = (wcount > PW'(DEPTH / 2));
   assign almost_full = (free <= {1'b0, af_lvl});
   assign mem_we      = wen & ~full;
   assign wptr_nx     = wptr + 1'b1;
   assign flag_f      = (mode_q == MODE_FWFT) ? ~full : full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         wgray <= '0;
      end else if (mem_we) begin
         wptr  <= wptr_nx;
         wgray <= wptr_nx ^ (wptr_nx >> 1);
      end
   end
endmodule

// File: rtl/dcx_rd_ctl.sv
module dcx_rd_ctl
   import dcx_fifo_pkg::*;
#(
   parameter  int DEPTH = 64,
   localparam int AW    = $clog2(DEPTH),
   localparam int PW    = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mrst_n,
   input  logic              mode_pin,
   input  logic              ren,
   input  logic              rewind,
   input  logic [PW-1:0]     wgray_s,
   input  logic [PW-1:0]     ae_lvl,
   input  logic [DATA_W-1:0] mem_q,
   output logic [PW-1:0]     rptr,
   output logic [PW-1:0]     rgray,
   output logic [DATA_W-1:0] dout,
   output logic              flag_e,
   output logic              almost_empty,
   output logic              mem_empty,
   output logic              fwft
);
   fifo_mode_e    mode_q;
   logic [PW-1:0] wbin;
   logic [PW-1:0] mcount;
   logic [PW:0]   count;
   logic [PW-1:0] rptr_nx;
   logic          ov;
   logic          fetch;

   always_ff @(posedge clk) begin
      if (!mrst_n) mode_q <= fifo_mode_e'(mode_pin);
   end

   always_comb begin
      for (int i = 0; i < PW; i++) wbin[i] = ^(wgray_s >> i);
   end

   assign fwft         = (mode_q == MODE_FWFT);
   assign mcount       = wbin - rptr;
   assign mem_empty    = (mcount == '0);
   assign count        = {1'b0, mcount} + {{PW{1'b0}}, ov};
   assign almost_empty = (count <= {1'b0, ae_lvl});
   assign fetch        = ~rewind & ~mem_empty & (fwft ? (~ov | ren) : ren);
   assign rptr_nx      = rptr + 1'b1;
   assign flag_e       = fwft ? ov : mem_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr  <= '0;
         rgray <= '0;
         ov    <= 1'b0;
         dout  <= '0;
      end else if (rewind) begin
         rptr  <= '0;
         rgray <= '0;
         ov    <= 1'b0;
      end else begin
         if (fetch) begin
            rptr  <= rptr_nx;
            rgray <= rptr_nx ^ (rptr_nx >> 1);
            dout  <= mem_q;
         end
         ov <= fwft & (fetch | (ov & ~ren));
      end
   end
endmodule

// File: rtl/dcx_fifo.sv
module dcx_fifo
   import dcx_fifo_pkg::*;
#(
   parameter  int DEPTH       = 64,
   parameter  int SYNC_STAGES = 2,
   localparam int AW          = $clog2(DEPTH),
   localparam int PW          = AW + 1
) (
   input  logic              wclk,
   input  logic              rclk,
   input  logic              mrst_n,
   input  logic              prst_n,
   input  logic              fwft_sel,
   input  logic              wen,
   input  logic [DATA_W-1:0] din,
   input  logic              ren,
   input  logic              rewind,
   input  logic [PW-1:0]     ae_lvl,
   input  logic [PW-1:0]     af_lvl,
   output logic [DATA_W-1:0] dout,
   output logic              rd_flag,
   output logic              wr_flag,
   output logic              half_full,
   output logic              almost_empty,
   output logic              almost_full
);
   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("dcx_fifo: DEPTH must be a power of two, at least 4");
      end
   endgenerate

   logic              rst_any_n;
   logic [PW-1:0]     wptr_b, wgray, wgray_s;
   logic [PW-1:0]     rptr_b, rgray, rgray_s;
   logic              mem_we, w_full, r_mem_empty, r_fwft;
   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] mem_q;

   assign rst_any_n = mrst_n & prst_n;

   always_ff @(posedge wclk) begin
      if (mem_we) mem[wptr_b[AW-1:0]] <= din;
   end
   assign mem_q = mem[rptr_b[AW-1:0]];

   dcx_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rclk), .rst_n(rst_any_n), .d_gray(wgray), .q_gray(wgray_s));

   dcx_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wclk), .rst_n(rst_any_n), .d_gray(rgray), .q_gray(rgray_s));

   dcx_wr_ctl #(.DEPTH(DEPTH)) u_wr (
      .clk(wclk), .rst_n(rst_any_n), .mrst_n(mrst_n), .mode_pin(fwft_sel),
      .wen(wen), .rgray_s(rgray_s), .af_lvl(af_lvl),
      .wptr(wptr_b), .wgray(wgray), .mem_we(mem_we), .full(w_full),
      .flag_f(wr_flag), .half_full(half_full), .almost_full(almost_full));

   dcx_rd_ctl #(.DEPTH(DEPTH)) u_rd (
      .clk(rclk), .rst_n(rst_any_n), .mrst_n(mrst_n), .mode_pin(fwft_sel),
      .ren(ren), .rewind(rewind), .wgray_s(wgray_s), .ae_lvl(ae_lvl),
      .mem_q(mem_q), .rptr(rptr_b), .rgray(rgray), .dout(dout),
      .flag_e(rd_flag), .almost_empty(almost_empty),
      .mem_empty(r_mem_empty), .fwft(r_fwft));
endmodule

// File: rtl/dcx_fifo_chk.sv
module dcx_fifo_chk #(
   parameter  int DEPTH = 64,
   parameter  int DW    = 18,
   localparam int PW    = $clog2(DEPTH) + 1
) (
   input logic          wclk,
   input logic          rclk,
   input logic          rst_n,
   input logic          mrst_n,
   input logic          wen,
   input logic          ren,
   input logic          rewind,
   input logic          wfull,
   input logic          rempty,
   input logic          fwft,
   input logic          rd_flag,
   input logic [DW-1:0] dout,
   input logic [PW-1:0] wptr,
   input logic [PW-1:0] rptr
);
   p_no_overflow_r4: assert property (@(posedge wclk) disable iff (!rst_n)
      (wfull && wen) |=> $stable(wptr))
      else $error("write pointer moved while full");

   p_no_underflow_r5: assert property (@(posedge rclk) disable iff (!rst_n)
      (rempty && !rewind) |=> $stable(rptr))
      else $error("read pointer moved while empty");

   p_rewind_first_r10: assert property (@(posedge rclk) disable iff (!rst_n)
      rewind |=> (rptr == '0))
      else $error("rewind did not return read pointer to first location");

   p_mode_kept_r2: assert property (@(posedge rclk) disable iff (!mrst_n)
      1'b1 |=> $stable(fwft))
      else $error("mode changed outside master reset");

   p_head_held_r9: assert property (@(posedge rclk) disable iff (!rst_n)
      (fwft && rd_flag && !ren && !rewind) |=> (rd_flag && $stable(dout)))
      else $error("fall-through head word not held");
endmodule

bind dcx_fifo dcx_fifo_chk #(.DEPTH(DEPTH), .DW(dcx_fifo_pkg::DATA_W)) u_chk (
   .wclk(wclk), .rclk(rclk), .rst_n(rst_any_n), .mrst_n(mrst_n),
   .wen(wen), .ren(ren), .rewind(rewind), .wfull(w_full),
   .rempty(r_mem_empty), .fwft(r_fwft), .rd_flag(rd_flag), .dout(dout),
   .wptr(wptr_b), .rptr(rptr_b));

// File: tb/dcx_fifo_tb_top.sv
module dcx_fifo_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int RCLK_PERIOD = CLK_PERIOD + 4;
   localparam int DEPTH = 64;
   localparam int PW = $clog2(DEPTH) + 1;

   logic wclk = 1'b0, rclk = 1'b0;
   logic mrst_n = 1'b0, prst_n = 1'b1, fwft_sel = 1'b0;
   logic wen = 1'b0, ren = 1'b0, rewind = 1'b0;
   logic [17:0] din = '0;
   logic [PW-1:0] ae_lvl = PW'(2), af_lvl = PW'(4);
   logic [17:0] dout;
   logic rd_flag, wr_flag, half_full, almost_empty, almost_full;

   int checks = 0, errors = 0;
   logic [17:0] exp_q[$];
   logic [17:0] hist[$];
   bit mode_b = 1'b0;
   bit pend_std = 1'b0;

   always #(CLK_PERIOD / 2) wclk = ~wclk;
   always #(RCLK_PERIOD / 2) rclk = ~rclk;

   dcx_fifo #(.DEPTH(DEPTH)) dut_i (
      .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
      .fwft_sel(fwft_sel), .wen(wen), .din(din), .ren(ren), .rewind(rewind),
      .ae_lvl(ae_lvl), .af_lvl(af_lvl), .dout(dout), .rd_flag(rd_flag),
      .wr_flag(wr_flag), .half_full(half_full), .almost_empty(almost_empty),
      .almost_full(almost_full));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Monitor: pops the scoreboard as the design delivers words.
   always @(negedge rclk) begin
      if (pend_std) begin
         if (exp_q.size() == 0) chk("R3 unexpected word", 32'(dout), 32'hdead);
         else chk("R3 standard read data", 32'(dout), 32'(exp_q.pop_front()));
      end
      pend_std = 1'b0;
      if (mrst_n && prst_n) begin
         if (rewind) exp_q = hist;
         else if (!mode_b && ren && !rd_flag) pend_std = 1'b1;
         else if (mode_b && ren && rd_flag) begin
            if (exp_q.size() == 0) chk("R9 unexpected word", 32'(dout), 32'hdead);
            else chk("R9 fall-through read data", 32'(dout), 32'(exp_q.pop_front()));
         end
      end
   end

   task automatic settle();
      repeat (8) @(posedge rclk);
      @(negedge rclk);
   endtask

   task automatic master_reset(input bit fw);
      @(posedge rclk); #1;
      mrst_n = 1'b0; fwft_sel = fw; wen = 0; ren = 0; rewind = 0;
      repeat (4) @(posedge rclk);
      #1;
      exp_q.delete(); hist.delete(); mode_b = fw;
      mrst_n = 1'b1;
      settle();
   endtask

   task automatic partial_reset();
      @(posedge rclk); #1;
      prst_n = 1'b0;
      repeat (2) @(posedge rclk);
      #1;
      exp_q.delete(); hist.delete();
      prst_n = 1'b1;
   endtask

   // Driver: writes n words; pushes them to the scoreboard if acceptance is expected.
   task automatic write_n(input int n, input logic [17:0] base, input bit keep);
      for (int i = 0; i < n; i++) begin
         @(posedge wclk); #1;
         wen = 1'b1; din = base + 18'(i);
         if (keep) begin exp_q.push_back(din); hist.push_back(din); end
      end
      @(posedge wclk); #1;
      wen = 1'b0;
   endtask

   task automatic read_n(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge rclk); #1;
         ren = 1'b1;
      end
      @(posedge rclk); #1;
      ren = 1'b0;
   endtask

   task automatic do_rewind(input bit with_read);
      @(posedge rclk); #1;
      rewind = 1'b1; ren = with_read;
      @(posedge rclk); #1;
      rewind = 1'b0; ren = 1'b0;
   endtask

   initial begin
      #(150000 * CLK_PERIOD);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // Standard mode reset state
      master_reset(1'b0);
      chk("R1 std rd_flag", 32'(rd_flag), 1);
      chk("R1 std wr_flag", 32'(wr_flag), 0);
      chk("R1 half_full", 32'(half_full), 0);
      chk("R1 almost_empty", 32'(almost_empty), 1);
      chk("R1 almost_full", 32'(almost_full), 0);

      // Almost-empty boundary and ordered reads
      write_n(2, 18'h100, 1); settle();
      chk("R8 almost_empty at count 2", 32'(almost_empty), 1);
      chk("R6 not empty", 32'(rd_flag), 0);
      write_n(1, 18'h102, 1); settle();
      chk("R8 almost_empty at count 3", 32'(almost_empty), 0);
      read_n(3); settle();
      chk("R6 empty after draining", 32'(rd_flag), 1);
      chk("R3 all words delivered", exp_q.size(), 0);

      // Reads while empty are ignored
      read_n(2); settle();
      chk("R5 still empty", 32'(rd_flag), 1);
      write_n(1, 18'h2AA, 1); settle();
      read_n(1); settle();
      chk("R5 pointer unmoved, next word correct", 32'(dout), 32'h2AA);

      // Fill: half, almost-full, full, overflow
      write_n(32, 18'h1000, 1); settle();
      chk("R7 half_full at DEPTH/2", 32'(half_full), 0);
      write_n(1, 18'h1020, 1); settle();
      chk("R7 half_full above DEPTH/2", 32'(half_full), 1);
      write_n(26, 18'h1021, 1); settle();
      chk("R8 almost_full with free 5", 32'(almost_full), 0);
      write_n(1, 18'h103B, 1); settle();
      chk("R8 almost_full with free 4", 32'(almost_full), 1);
      write_n(3, 18'h103C, 1); settle();
      chk("R6 not full at DEPTH-1", 32'(wr_flag), 0);
      write_n(1, 18'h103F, 1); settle();
      chk("R6 full at DEPTH", 32'(wr_flag), 1);
      write_n(2, 18'h3FFFF, 0); settle();
      chk("R4 still full", 32'(wr_flag), 1);
      read_n(DEPTH); settle();
      chk("R4 dropped words absent", 32'(rd_flag), 1);
      chk("R4 scoreboard drained", exp_q.size(), 0);

      // Rewind colliding with a read in standard mode
      master_reset(1'b0);
      write_n(4, 18'h50, 1); settle();
      read_n(2); settle();
      do_rewind(1'b1); settle();
      read_n(4); settle();
      chk("R10 replay complete", exp_q.size(), 0);
      chk("R10 empty after replay", 32'(rd_flag), 1);

      // Fall-through mode
      master_reset(1'b1);
      chk("R1 fwft rd_flag", 32'(rd_flag), 0);
      chk("R1 fwft wr_flag", 32'(wr_flag), 1);
      chk("R1 fwft almost_empty", 32'(almost_empty), 1);
      fwft_sel = 1'b0;
      write_n(1, 18'h77, 1); settle();
      chk("R9 output ready without read", 32'(rd_flag), 1);
      chk("R9 first word on dout", 32'(dout), 32'h77);
      chk("R2 mode kept after pin change", 32'(wr_flag), 1);
      write_n(3, 18'h80, 1); settle();
      read_n(4); settle();
      chk("R9 not ready when drained", 32'(rd_flag), 0);
      chk("R9 scoreboard drained", exp_q.size(), 0);

      do_rewind(1'b0); settle();
      chk("R10 fwft ready after rewind", 32'(rd_flag), 1);
      chk("R10 fwft first word again", 32'(dout), 32'h77);
      read_n(4); settle();
      chk("R10 fwft replay complete", exp_q.size(), 0);

      // Partial reset keeps fall-through mode
      partial_reset(); settle();
      chk("R11 empty after partial reset", 32'(rd_flag), 0);
      chk("R11 mode kept, input ready", 32'(wr_flag), 1);
      write_n(1, 18'h5A5, 1); settle();
      chk("R11 falls through after partial reset", 32'(rd_flag), 1);
      chk("R11 word on dout", 32'(dout), 32'h5A5);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule